// File: doc/BRIEF.md
# Glitch-Free Three-Bank Clock Divider

This block takes one fast source clock and produces three banks of four divided clocks each. Each bank has its own 2-bit divisor select. A shared range input halves every bank's divisor when high and doubles it when low. Each bank runs one counter in the source-clock domain, and all four lanes of the bank are driven from that counter. A control input inverts two lanes of the third bank. An active-low reset clears all state and holds every output low.

The selects, the range input and the inversion control are registered before use. The selects and the range input may change while the block runs. A new divisor takes effect only at the end of a full period of the current divisor. As a result, no output period is shorter or longer than both the old and the new period. All banks start from a common phase when reset is released, so their rising edges line up wherever their periods share a multiple.

Top module: `tri_bank_clkdiv`

## Requirements
- R1: With `range_hi`=1, bank A divides the source by 4, 6, 8 or 12 for `sel_a` codes 00, 01, 10 and 11.
- R2: With `range_hi`=1, bank B divides by 4, 6, 8 or 10 for `sel_b` codes 00, 01, 10 and 11.
- R3: With `range_hi`=1, bank C divides by 2, 4, 6 or 8 for `sel_c` codes 00, 01, 10 and 11.
- R4: With `range_hi`=0, every bank divisor is twice its R1–R3 value: A 8/12/16/24, B 8/12/16/20, C 4/8/12/16.
- R5: When any select or `range_hi` changes during operation, every completed output period equals either the old divisor or the new one. The new divisor starts at a rising-edge boundary.
- R6: Every output period is high for exactly the first half of its source cycles and low for the second half.
- R7: The four lanes of a bank toggle together: bit 0 through bit 3 of `q_a`, `q_b` and `q_c` are identical, except for the inversion in R8.
- R8: When `invert_c`=1, `q_c[3]` and `q_c[2]` are the complement of `q_c[0]`. When `invert_c`=0, they equal it.
- R9: While `rst_n`=0, all twelve outputs are 0, including the inverted lanes.
- R10: On the first source edge after `rst_n` rises, every bank begins a period, so all uninverted outputs go high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| range_hi | input | 1 | 1: base divisors; 0: all divisors doubled |
| sel_a | input | 2 | Bank A divisor select |
| sel_b | input | 2 | Bank B divisor select |
| sel_c | input | 2 | Bank C divisor select |
| invert_c | input | 1 | Inverts lanes 2 and 3 of bank C |
| q_a | output | 4 | Bank A divided clocks |
| q_b | output | 4 | Bank B divided clocks |
| q_c | output | 4 | Bank C divided clocks |

## Verification
The assertions check four properties on every cycle:
- the counter stays below the active divisor;
- the active divisor holds except at the last count of a period;
- an output rises only at count zero;
- an output falls only at the half-period count.

Only the bench scenarios can show the divisor tables for each bank and range. The same holds for the bounded number of old-length periods after a live change, equal lanes, C-lane inversion, quiet outputs in reset, and the common first edge after release. The bench shows these by measuring completed periods and their high times at the ports.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic [1:0] {BANK_A = 2'd0, BANK_B = 2'd1, BANK_C = 2'd2} bank_e;

   localparam int unsigned MAX_DIV = 24;

   // Base divisor at range_hi = 1; doubled when range_hi = 0.
   function automatic int unsigned div_of(bank_e kind, logic range_hi, logic [1:0] sel);
      int unsigned base;
      base = 4;
      case (kind)
         BANK_A: case (sel)
                    2'd0: base = 4;
                    2'd1: base = 6;
                    2'd2: base = 8;
                    default: base = 12;
                 endcase
         BANK_B: case (sel)
                    2'd0: base = 4;
                    2'd1: base = 6;
                    2'd2: base = 8;
                    default: base = 10;
                 endcase
         default: case (sel)
                    2'd0: base = 2;
                    2'd1: base = 4;
                    2'd2: base = 6;
                    default: base = 8;
                 endcase
      endcase
      return range_hi ? base : base * 2;
   endfunction

endpackage

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
   import clkdiv_pkg::*;
#(
   parameter bank_e            KIND     = BANK_A,
   parameter int               CNT_W    = 5,
   parameter int               LANES    = 4,
   parameter logic [LANES-1:0] INV_MASK = '0
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic             range_hi,
   input  logic [1:0]       sel,
   input  logic             invert,
   output logic [LANES-1:0] q
);

   generate
      if (MAX_DIV > (1 << CNT_W) - 1) begin : g_bad_width
         $error("clkdiv_bank: CNT_W too small for MAX_DIV");
      end
      if (INV_MASK[0] != 1'b0) begin : g_bad_mask
         $error("clkdiv_bank: lane 0 must stay uninverted");
      end
   endgenerate

   logic [1:0]       sel_q;
   logic             range_q;
   logic             inv_q;
   logic             started;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic [CNT_W-1:0] div_cur, div_n, div_new;
   logic             wrap;
   logic             phase_hi;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         range_q <= 1'b0;
         inv_q   <= 1'b0;
      end else begin
         sel_q   <= sel;
         range_q <= range_hi;
         inv_q   <= invert;
      end
   end

   assign div_new = CNT_W'(div_of(KIND, range_q, sel_q));
   assign wrap    = started && (cnt == div_cur - 1'b1);

   always_comb begin
      if (!started || wrap) begin
         cnt_n = '0;
         div_n = div_new;
      end else begin
         cnt_n = cnt + 1'b1;
         div_n = div_cur;
      end
   end

   assign phase_hi = (cnt_n < (div_n >> 1));

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         cnt     <= '0;
         div_cur <= '0;
      end else begin
         started <= 1'b1;
         cnt     <= cnt_n;
         div_cur <= div_n;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk_src or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= phase_hi ^ (INV_MASK[i] & inv_q);
      end
   end

   AST_CNT_BELOW_DIV: assert property (@(posedge clk_src) disable iff (!rst_n)
      started |-> (cnt < div_cur)); // R1

   AST_DIV_HOLDS_MIDPERIOD: assert property (@(posedge clk_src) disable iff (!rst_n)
      (started && (cnt != div_cur - 1'b1)) |=> $stable(div_cur)); // R5

   AST_RISE_AT_ZERO: assert property (@(posedge clk_src) disable iff (!rst_n)
      $rose(q[0]) |-> (cnt == '0)); // R6

   AST_FALL_AT_HALF: assert property (@(posedge clk_src) disable iff (!rst_n)
      $fell(q[0]) |-> (cnt == (div_cur >> 1))); // R6

endmodule

// File: rtl/tri_bank_clkdiv.sv
module tri_bank_clkdiv
   import clkdiv_pkg::*;
#(
   parameter int         CNT_W      = 5,
   parameter int         LANES      = 4,
   parameter logic [3:0] C_INV_MASK = 4'b1100
) (
   input  logic       clk_src,
   input  logic       rst_n,
   input  logic       range_hi,
   input  logic [1:0] sel_a,
   input  logic [1:0] sel_b,
   input  logic [1:0] sel_c,
   input  logic       invert_c,
   output logic [3:0] q_a,
   output logic [3:0] q_b,
   output logic [3:0] q_c
);

   localparam int NBANK = 3;

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("tri_bank_clkdiv: port widths assume four lanes per bank");
      end
   endgenerate

   logic [NBANK-1:0][1:0]       sel_all;
   logic [NBANK-1:0][LANES-1:0] q_all;

   assign sel_all = {sel_c, sel_b, sel_a};

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      localparam logic [LANES-1:0] MASK = (g == 2) ? C_INV_MASK : '0;
      clkdiv_bank #(
         .KIND     (bank_e'(g)),
         .CNT_W    (CNT_W),
         .LANES    (LANES),
         .INV_MASK (MASK)
      ) u_bank (
         .clk_src  (clk_src),
         .rst_n    (rst_n),
         .range_hi (range_hi),
         .sel      (sel_all[g]),
         .invert   (invert_c),
         .q        (q_all[g])
      );
   end

   assign q_a = q_all[0];
   assign q_b = q_all[1];
   assign q_c = q_all[2];

endmodule

// File: tb/sim_tri_bank_clkdiv.sv
`timescale 1ns/1ps
module sim_tri_bank_clkdiv;

   logic       clk_src = 1'b0;
   logic       rst_n = 1'b0;
   logic       range_hi = 1'b0;
   logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
   logic       invert_c = 1'b0;
   logic [3:0] q_a, q_b, q_c;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk_src = ~clk_src;

   tri_bank_clkdiv u0 (
      .clk_src(clk_src), .rst_n(rst_n), .range_hi(range_hi),
      .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .invert_c(invert_c),
      .q_a(q_a), .q_b(q_b), .q_c(q_c)
   );

   // Scoreboard state
   int  exp_q [3][$];
   int  old_div [3];
   int  allow [3];
   bit  mon_en = 0;
   bit  inv_exp = 0;
   bit  lane_skip = 0;
   bit  prev [3];
   bit  seen [3];
   int  cyc [3];
   int  hic [3];

   function automatic int ref_div(int b, bit r, int s);
      int t;
      if (b == 0)      t = (s == 0) ? 4 : (s == 1) ? 6 : (s == 2) ? 8 : 12;  // R1
      else if (b == 1) t = (s == 0) ? 4 : (s == 1) ? 6 : (s == 2) ? 8 : 10;  // R2
      else             t = (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 6 : 8;   // R3
      return r ? t : 2 * t;                                                  // R4
   endfunction

   function automatic string req_of(int b);
      if (!range_hi) return "R4";
      return (b == 0) ? "R1" : (b == 1) ? "R2" : "R3";
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Driver: apply a configuration and queue the expected periods
   task automatic apply_cfg(bit r, int sa, int sb, int sc, int n);
      @(negedge clk_src);
      range_hi = r; sel_a = 2'(sa); sel_b = 2'(sb); sel_c = 2'(sc);
      for (int b = 0; b < 3; b++) begin
         int d;
         d = ref_div(b, r, (b == 0) ? sa : (b == 1) ? sb : sc);
         allow[b] = 2;
         for (int k = 0; k < n; k++) exp_q[b].push_back(d);
      end
      while (exp_q[0].size() + exp_q[1].size() + exp_q[2].size() != 0)
         @(negedge clk_src);
   endtask

   task automatic set_invert(bit v);
      @(negedge clk_src);
      lane_skip = 1;
      invert_c = v;
      repeat (3) @(negedge clk_src);
      inv_exp = v;
      lane_skip = 0;
   endtask

   // Monitor: measure each completed period of lane 0 per bank
   always @(negedge clk_src) begin
      if (mon_en) begin
         for (int b = 0; b < 3; b++) begin
            bit cur;
            cur = (b == 0) ? q_a[0] : (b == 1) ? q_b[0] : q_c[0];
            if (cur && !prev[b]) begin
               if (seen[b]) begin
                  int p;
                  p = cyc[b];
                  if (exp_q[b].size() > 0 && p == exp_q[b][0]) begin
                     chk(1'b1, req_of(b), "period", p, exp_q[b][0]);
                     void'(exp_q[b].pop_front());
                     old_div[b] = p;
                  end else if (p == old_div[b] && (allow[b] > 0 || exp_q[b].size() == 0)) begin
                     if (exp_q[b].size() > 0) allow[b]--;
                     chk(1'b1, "R5", "transition period", p, old_div[b]);
                  end else begin
                     chk(1'b0, "R5", "period not old or new",
                         p, (exp_q[b].size() > 0) ? exp_q[b][0] : old_div[b]);
                  end
                  chk(hic[b] == p / 2, "R6", "high time", hic[b], p / 2);
               end
               // Lane agreement at each rising edge (R7, R8)
               if (!lane_skip) begin
                  if (b == 0) chk(q_a == 4'hF, "R7", "bank A lanes", int'(q_a), 15);
                  if (b == 1) chk(q_b == 4'hF, "R7", "bank B lanes", int'(q_b), 15);
                  if (b == 2) begin
                     chk(q_c[1:0] == 2'b11, "R7", "bank C lanes 0-1", int'(q_c[1:0]), 3);
                     chk(q_c[3:2] == (inv_exp ? 2'b00 : 2'b11), "R8", "bank C lanes 2-3",
                         int'(q_c[3:2]), inv_exp ? 0 : 3);
                  end
               end
               cyc[b] = 1; hic[b] = 1; seen[b] = 1;
            end else begin
               cyc[b]++;
               if (cur) hic[b]++;
            end
            prev[b] = cur;
         end
      end
   end

   task automatic start_monitor();
      for (int b = 0; b < 3; b++) begin
         prev[b] = 0; seen[b] = 0; cyc[b] = 0; hic[b] = 0; allow[b] = 0;
         old_div[b] = ref_div(b, range_hi, (b == 0) ? int'(sel_a) : (b == 1) ? int'(sel_b) : int'(sel_c));
      end
      mon_en = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_src);
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finish_run();
   end

   initial begin
      // R9: outputs low in reset
      repeat (3) @(negedge clk_src);
      chk({q_a, q_b, q_c} == 12'h000, "R9", "outputs in reset", int'({q_a, q_b, q_c}), 0);

      // R10: common first edge after release
      @(negedge clk_src);
      rst_n = 1'b1;
      start_monitor();
      #0;
      @(negedge clk_src);
      chk({q_a, q_b, q_c} == 12'hFFF, "R10", "first cycle after release", int'({q_a, q_b, q_c}), 4095);

      apply_cfg(1'b0, 0, 0, 0, 3);   // R4 low range
      apply_cfg(1'b1, 0, 0, 0, 4);   // R1 R2 R3 code 00
      apply_cfg(1'b1, 1, 1, 1, 4);
      apply_cfg(1'b1, 2, 2, 2, 4);
      apply_cfg(1'b1, 3, 3, 3, 4);
      apply_cfg(1'b0, 3, 3, 3, 3);   // R4, live range change R5
      set_invert(1'b1);              // R8
      apply_cfg(1'b0, 1, 2, 3, 3);
      apply_cfg(1'b1, 3, 0, 0, 4);   // R5 large jump
      apply_cfg(1'b1, 0, 3, 2, 4);
      set_invert(1'b0);
      apply_cfg(1'b0, 2, 1, 1, 3);

      // R9: reset while running clears outputs, inversion included
      set_invert(1'b1);
      mon_en = 0;
      @(negedge clk_src);
      rst_n = 1'b0;
      @(negedge clk_src);
      chk({q_a, q_b, q_c} == 12'h000, "R9", "outputs after mid-run reset", int'({q_a, q_b, q_c}), 0);
      @(negedge clk_src);
      rst_n = 1'b1;
      @(negedge clk_src);
      chk({q_a, q_b[0], q_c[1:0]} == 7'h7F, "R10", "restart edge", int'({q_a, q_b[0], q_c[1:0]}), 127);
      repeat (4) @(negedge clk_src);
      finish_run();
   end

endmodule